// File: doc/BRIEF.md
# Chip Phase Stepper with Tau-Dither

This block produces the chip-clock enable that drives the receive pseudo-noise code generator. A chip nominally lasts a fixed number of master clocks (16 by default), and the phase of the chip grid can be moved in steps of one master clock, that is, one sixteenth of a chip. An external controller closes a tracking loop around the block. It pulses an update input, and an advance level chooses the direction. Each accepted update moves every later chip boundary earlier or later by a programmed step size.

The block also contains a tau-dither generator. When dither is enabled, the chip grid switches between an undithered position and a position retarded by a programmed amount, once per duplex cycle. The grid is never advanced by dither. A status output reports whether the retard is currently applied, so the controller can compare signal strength between the two states. A new dither amount takes effect only after the receive code has been reloaded.

Top module: `chip_phase_dither`

## Requirements
- R1: `chipEn` is a one-cycle pulse at each chip boundary, `SUB_PER_CHIP` (16) clocks apart when no adjustment is pending. No single chip period is shorter than half or longer than twice that value. Any adjustment beyond those limits carries into the following chips without loss.
- R2: The synchronized rising edge of `updateIn` is accepted with the `advanceIn` level sampled through the same synchronizer. After an accepted update, all later chip pulses move earlier when the level is 1 and later when it is 0.
- R3: The 3-bit `stepSize` value n moves the grid by n+1 clocks, so a step is between 1 and 8 sixteenths of a chip.
- R4: A rising edge of `updateIn` that arrives fewer than `MIN_UPD_GAP` (32) clocks after the last accepted one is ignored and leaves the phase unchanged.
- R5: With `ditherEn` high, `ditherRetarded` changes state every `FRAME_CLKS` (2048) clocks, which is one duplex cycle. While it is high, the chip grid lies later than the undithered grid by the dither amount. While it is low, the grid is undithered. Dither never advances the grid.
- R6: After `ditherEn` goes low, `ditherRetarded` falls at the next frame boundary at the latest and then stays low. Once it has fallen, the grid is undithered.
- R7: The dither amount is 2·td+1 clocks, where td is the 3-bit `ditherAmp`. It is captured only when `codeReload` pulses and is 1 clock after reset. Changing `ditherAmp` without a reload has no effect. A retard that is already applied is removed by the same amount that was added.
- R8: During reset, `chipEn` and `ditherRetarded` are low. The first chip pulse follows after exactly `SUB_PER_CHIP` clocks, with zero offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| updateIn | input | 1 | Asynchronous step request; the rising edge counts |
| advanceIn | input | 1 | Step direction: 1 moves earlier, 0 moves later |
| stepSize | input | 3 | Step size n; the step is n+1 clocks |
| ditherEn | input | 1 | Enables the tau-dither alternation |
| ditherAmp | input | 3 | Dither amount td; the amount is 2·td+1 clocks |
| codeReload | input | 1 | One-cycle strobe marking a receive code reload; captures the dither amount |
| chipEn | output | 1 | One-cycle chip boundary enable for the receive code generator |
| ditherRetarded | output | 1 | High while the dither retard is applied |

## Verification
The bench measures the position of every chip pulse against an ideal 16-clock grid and predicts its offset from the steps and dither states it has seen. Several cases are targeted. A dropped or doubled carry of stacked retards would leave a permanent offset error. An update 20 clocks after the previous one must not move the grid, while one 40 clocks after must. A dither retard entered with a stale or premature amount would show as an error only in the retarded frames. The bench also changes `ditherAmp` without a reload and then reloads while the retard is applied. This exposes a design that removes the new amount instead of the one it added, because the grid would drift by the difference. After `ditherEn` is cleared, the bench confirms that the status output falls and stays low.

// File: rtl/chip_phase_pkg.sv
`timescale 1ns/1ps
package chip_phase_pkg;
  localparam int STEP_W = 3;
  localparam int AMT_W  = 4;

  // Strobes from control to datapath, valid for one clock.
  typedef struct packed {
    logic             stepGo;
    logic             stepAdv;
    logic [AMT_W-1:0] stepAmt;
    logic             ditherOn;
    logic             ditherOff;
    logic [AMT_W-1:0] ditherAmt;
  } adjStrobes_t;
endpackage

// File: rtl/cpd_ctrl.sv
`timescale 1ns/1ps
module cpd_ctrl
  import chip_phase_pkg::*;
#(
  parameter int FRAME_CLKS  = 2048,
  parameter int MIN_GAP     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              updateIn,
  input  logic              advanceIn,
  input  logic [STEP_W-1:0] stepSize,
  input  logic              ditherEn,
  input  logic [STEP_W-1:0] ditherAmp,
  input  logic              codeReload,
  output adjStrobes_t       strb,
  output logic              ditherRetarded
);
  localparam int FRAME_W = $clog2(FRAME_CLKS);
  localparam int GAP_W   = $clog2(MIN_GAP + 1);

  logic [SYNC_STAGES:0]   updPipe;
  logic [SYNC_STAGES-1:0] advPipe;
  logic [GAP_W-1:0]       gapCnt;
  logic [FRAME_W-1:0]     frameCnt;
  logic [AMT_W-1:0]       ampLatched;
  logic [AMT_W-1:0]       ampApplied;
  logic updRise, accept, frameTick, enterRet, leaveRet;

  // Synchronizer chains; the last stage of updPipe is the edge reference.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      updPipe <= '0;
      advPipe <= '0;
    end else begin
      updPipe <= {updPipe[SYNC_STAGES-1:0], updateIn};
      advPipe <= {advPipe[SYNC_STAGES-2:0], advanceIn};
    end
  end

  assign updRise   = updPipe[SYNC_STAGES-1] & ~updPipe[SYNC_STAGES];
  assign accept    = updRise && (gapCnt == '0);
  assign frameTick = (frameCnt == FRAME_W'(FRAME_CLKS - 1));
  assign enterRet  = frameTick && ditherEn && !ditherRetarded;
  assign leaveRet  = frameTick && ditherRetarded;

  // Blanking window after an accepted update.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             gapCnt <= '0;
    else if (accept)       gapCnt <= GAP_W'(MIN_GAP - 1);
    else if (gapCnt != '0) gapCnt <= gapCnt - GAP_W'(1);
  end

  // Duplex frame timer: one tick per duplex cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          frameCnt <= '0;
    else if (frameTick) frameCnt <= '0;
    else                frameCnt <= frameCnt + FRAME_W'(1);
  end

  // Dither amount is captured on code reload as 2*td+1.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           ampLatched <= AMT_W'(1);
    else if (codeReload) ampLatched <= {ditherAmp, 1'b1};
  end

  // Dither state and the amount currently applied.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ditherRetarded <= 1'b0;
      ampApplied     <= '0;
    end else if (enterRet) begin
      ditherRetarded <= 1'b1;
      ampApplied     <= ampLatched;
    end else if (leaveRet) begin
      ditherRetarded <= 1'b0;
      ampApplied     <= '0;
    end
  end

  always_comb begin
    strb.stepGo    = accept;
    strb.stepAdv   = advPipe[SYNC_STAGES-1];
    strb.stepAmt   = AMT_W'(stepSize) + AMT_W'(1);
    strb.ditherOn  = enterRet;
    strb.ditherOff = leaveRet;
    strb.ditherAmt = enterRet ? ampLatched : ampApplied;
  end
endmodule

// File: rtl/cpd_datapath.sv
`timescale 1ns/1ps
module cpd_datapath
  import chip_phase_pkg::*;
#(
  parameter int SUB   = 16,
  parameter int ADJ_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  adjStrobes_t strb,
  output logic        chipEn
);
  localparam int PER_W = $clog2(2 * SUB + 1);
  localparam logic signed [ADJ_W-1:0] MAX_TAKE = ADJ_W'(SUB);
  localparam logic signed [ADJ_W-1:0] MIN_TAKE = -ADJ_W'(SUB / 2);

  logic signed [ADJ_W-1:0] adj, delta, take, stepV, ditherV;
  logic [PER_W-1:0] cnt, per;

  always_comb begin
    stepV   = strb.stepGo ? ADJ_W'(strb.stepAmt) : '0;
    ditherV = ADJ_W'(strb.ditherAmt);
    delta   = strb.stepAdv ? -stepV : stepV;
    if (strb.ditherOn)  delta = delta + ditherV;
    if (strb.ditherOff) delta = delta - ditherV;
    // Portion of the pending offset absorbed by the next chip period.
    if (adj > MAX_TAKE)      take = MAX_TAKE;
    else if (adj < MIN_TAKE) take = MIN_TAKE;
    else                     take = adj;
  end

  assign chipEn = (cnt == per - PER_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      per <= PER_W'(SUB);
      adj <= '0;
    end else if (chipEn) begin
      cnt <= '0;
      per <= PER_W'(SUB) + PER_W'(take);
      adj <= adj - take + delta;
    end else begin
      cnt <= cnt + PER_W'(1);
      adj <= adj + delta;
    end
  end
endmodule

// File: rtl/chip_phase_dither.sv
`timescale 1ns/1ps
module chip_phase_dither
  import chip_phase_pkg::*;
#(
  parameter int SUB_PER_CHIP = 16,
  parameter int FRAME_CLKS   = 2048,
  parameter int MIN_UPD_GAP  = 32,
  parameter int SYNC_STAGES  = 2,
  parameter int ADJ_W        = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              updateIn,
  input  logic              advanceIn,
  input  logic [STEP_W-1:0] stepSize,
  input  logic              ditherEn,
  input  logic [STEP_W-1:0] ditherAmp,
  input  logic              codeReload,
  output logic              chipEn,
  output logic              ditherRetarded
);
  adjStrobes_t strb;

  cpd_ctrl #(
    .FRAME_CLKS (FRAME_CLKS),
    .MIN_GAP    (MIN_UPD_GAP),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .updateIn      (updateIn),
    .advanceIn     (advanceIn),
    .stepSize      (stepSize),
    .ditherEn      (ditherEn),
    .ditherAmp     (ditherAmp),
    .codeReload    (codeReload),
    .strb          (strb),
    .ditherRetarded(ditherRetarded)
  );

  cpd_datapath #(
    .SUB  (SUB_PER_CHIP),
    .ADJ_W(ADJ_W)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .chipEn(chipEn)
  );
endmodule

// File: rtl/cpd_checker.sv
`timescale 1ns/1ps
module cpd_checker
  import chip_phase_pkg::*;
#(
  parameter int SUB     = 16,
  parameter int MIN_GAP = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              chipEn,
  input logic              ditherRetarded,
  input logic              ditherEn,
  input logic [STEP_W-1:0] ditherAmp,
  input logic              codeReload,
  input adjStrobes_t       strb
);
  localparam int CW = $clog2(2 * SUB + MIN_GAP + 2);

  logic [CW-1:0]    sinceGo, sinceChip;
  logic             seenChip;
  logic [AMT_W-1:0] ampModel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceGo   <= CW'(MIN_GAP);
      sinceChip <= '0;
      seenChip  <= 1'b0;
      ampModel  <= AMT_W'(1);
    end else begin
      if (strb.stepGo)                  sinceGo <= CW'(1);
      else if (sinceGo < CW'(MIN_GAP))  sinceGo <= sinceGo + CW'(1);
      if (chipEn)                           sinceChip <= CW'(1);
      else if (sinceChip < CW'(2 * SUB + 1)) sinceChip <= sinceChip + CW'(1);
      seenChip <= seenChip | chipEn;
      if (codeReload) ampModel <= {ditherAmp, 1'b1};
    end
  end

  AST_UPDATE_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepGo |-> sinceGo >= CW'(MIN_GAP)); // R4

  AST_CHIP_PERIOD_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (chipEn && seenChip) |-> (sinceChip >= CW'(SUB / 2) && sinceChip <= CW'(2 * SUB))); // R1

  AST_DITHER_AMOUNT: assert property (@(posedge clk) disable iff (!rstN)
    strb.ditherOn |-> strb.ditherAmt == ampModel); // R7

  AST_RETARD_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ditherRetarded) |-> $past(ditherEn)); // R6

  AST_STATUS_TRACKS_STROBES: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ditherRetarded) |-> $past(strb.ditherOn || strb.ditherOff)); // R5
endmodule

bind chip_phase_dither cpd_checker #(
  .SUB    (SUB_PER_CHIP),
  .MIN_GAP(MIN_UPD_GAP)
) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .chipEn        (chipEn),
  .ditherRetarded(ditherRetarded),
  .ditherEn      (ditherEn),
  .ditherAmp     (ditherAmp),
  .codeReload    (codeReload),
  .strb          (strb)
);

// File: tb/chip_phase_dither_test.sv
`timescale 1ns/1ps
module chip_phase_dither_test;
  localparam int SUB   = 16;
  localparam int FRAME = 2048;
  localparam int QUIET = 128;

  logic clk = 1'b0, rstN = 1'b0;
  logic updateIn = 1'b0, advanceIn = 1'b0, ditherEn = 1'b0, codeReload = 1'b0;
  logic [2:0] stepSize = 3'd0, ditherAmp = 3'd0;
  logic chipEn, ditherRetarded;

  int checks = 0, fails = 0;
  int cyc = 0, base = 0, idx = 0, expR = 0, ditherPart = 0, benchAmp = 1;
  int lastEvt = -1000, lastTog = -1;
  bit seenFirst = 1'b0, prevRet = 1'b0, done = 1'b0;
  string curTag = "R1 idle grid";

  always #2.5 clk = ~clk;

  chip_phase_dither uut (
    .clk(clk), .rstN(rstN), .updateIn(updateIn), .advanceIn(advanceIn),
    .stepSize(stepSize), .ditherEn(ditherEn), .ditherAmp(ditherAmp),
    .codeReload(codeReload), .chipEn(chipEn), .ditherRetarded(ditherRetarded)
  );

  function automatic int stepDelta(int n, bit adv);
    return adv ? -(n + 1) : (n + 1);
  endfunction

  function automatic int expPhase();
    return base + expR + ditherPart;
  endfunction

  task automatic check(int act, int exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: dither toggles and chip pulse positions.
  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (ditherRetarded !== prevRet) begin
        ditherPart = ditherRetarded ? benchAmp : 0;
        if (ditherEn && lastTog >= 0) check(cyc - lastTog, FRAME, "R5 toggle interval");
        lastTog = cyc;
        lastEvt = cyc;
        prevRet = ditherRetarded;
      end
      if (chipEn) begin
        if (!seenFirst) begin
          seenFirst = 1'b1;
          base = cyc;
          idx = 0;
          check(base, SUB, "R8 first chip pulse");
        end else begin
          idx++;
          if (cyc - lastEvt >= QUIET) check(cyc - SUB * idx, expPhase(), curTag);
        end
      end
    end
  end

  task automatic pulseUpdate(int n, bit adv, bit counted);
    @(negedge clk);
    stepSize  = n[2:0];
    advanceIn = adv;
    updateIn  = 1'b1;
    if (counted) expR += stepDelta(n, adv);
    lastEvt = cyc;
    repeat (4) @(negedge clk);
    updateIn = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitToggle();
    @(ditherRetarded);
    @(negedge clk);
  endtask

  task automatic reload(int td);
    @(negedge clk);
    ditherAmp  = td[2:0];
    codeReload = 1'b1;
    benchAmp   = 2 * td + 1;
    @(negedge clk);
    codeReload = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    bit stays;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    check(int'(chipEn), 0, "R8 chipEn in reset");
    check(int'(ditherRetarded), 0, "R8 dither status in reset");
    @(posedge clk);
    #1 rstN = 1'b1;
    idle(300);

    curTag = "R2 random steps";
    repeat (40) begin
      pulseUpdate(int'($urandom_range(7)), bit'($urandom_range(1)), 1'b1);
      idle(int'($urandom_range(250, 60)));
    end

    curTag = "R4 close update ignored";
    pulseUpdate(3, 1'b0, 1'b1);
    idle(15);
    pulseUpdate(5, 1'b1, 1'b0);
    idle(300);
    curTag = "R4 spaced update accepted";
    pulseUpdate(2, 1'b0, 1'b1);
    idle(35);
    pulseUpdate(6, 1'b1, 1'b1);
    idle(300);

    curTag = "R3 largest advance";
    pulseUpdate(7, 1'b1, 1'b1);
    idle(300);
    curTag = "R3 smallest retard";
    pulseUpdate(0, 1'b0, 1'b1);
    idle(300);
    curTag = "R1 stacked retard carry";
    repeat (3) begin pulseUpdate(7, 1'b0, 1'b1); idle(35); end
    idle(300);
    curTag = "R1 stacked advance carry";
    repeat (3) begin pulseUpdate(7, 1'b1, 1'b1); idle(35); end
    idle(300);

    curTag = "R5 dither amount 7";
    reload(3);
    lastTog = -1;
    ditherEn = 1'b1;
    repeat (4) begin
      waitToggle();
      idle(300);
      pulseUpdate(int'($urandom_range(7)), bit'($urandom_range(1)), 1'b1);
    end

    curTag = "R7 amount change without reload";
    ditherAmp = 3'd7;
    repeat (4) waitToggle();

    curTag = "R7 reload to amount 15";
    while (!ditherRetarded) waitToggle();
    idle(100);
    reload(7);
    repeat (4) begin
      waitToggle();
      idle(200);
    end

    curTag = "R6 dither disabled";
    lastTog = -1;
    ditherEn = 1'b0;
    while (ditherRetarded) @(negedge clk);
    stays = 1'b1;
    repeat (2 * FRAME) begin
      @(negedge clk);
      if (ditherRetarded) stays = 1'b0;
    end
    check(int'(stays), 1, "R6 status stays low");
    pulseUpdate(4, 1'b0, 1'b1);
    idle(400);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule